// File: doc/BRIEF.md
# Escape-Mode Low-Power Lane Encoder

This block drives the two single-ended wires of a serial display link's first data lane while that lane is in low-power escape mode. It is used to send configuration command bytes to a display. A controller first requests escape entry. The block then walks the wire pair through a fixed entry pattern. After that, the controller hands over command bytes one at a time. Each byte is sent bit by bit, with every bit marked on one wire and followed by a space state on both wires. A stop request walks the pair back to the idle high-high state.

A single `ready` flag throttles the caller. It is high only while the lane is parked, either in idle (both wires high) or in escape idle (both wires low). A request that arrives while `ready` is low is dropped. The caller therefore issues one-cycle pulses and waits for `ready` before issuing the next one.

Top module: `esc_lp_encoder`

## Requirements
- R1: After reset, and at every time afterwards that the wire pair is high-high (lp_p=1, lp_n=1), `ready` is high and the lane is idle.
- R2: An `esc_req` pulse sampled in idle drives the pair on the four following cycles to 10, 00, 01, 00 (written lp_p then lp_n), with `ready` low. On the fifth cycle the pair is 00 with `ready` high (escape idle).
- R3: A `byte_valid` pulse sampled in escape idle loads `cmd_byte`. The byte is then sent least significant bit first, two cycles per bit: a mark cycle (bit 1 gives 10, bit 0 gives 01) and then a space cycle (00). A byte therefore lasts 16 cycles.
- R4: `ready` stays low for the whole byte. It rises in the cycle after the last space state, with the pair at 00. A new byte may be loaded in that same cycle, so bytes can follow back to back.
- R5: A `stop_req` pulse sampled in escape idle drives the pair to 00 and then 10, with `ready` low. On the third cycle the pair is 11 and `ready` is high.
- R6: `byte_valid`, `stop_req`, `esc_req` and `cmd_byte` have no effect on the line sequence while `ready` is low. This covers entry, byte and stop sequences, including their final cycle.
- R7: `esc_req` sampled in escape idle is ignored. `byte_valid` and `stop_req` sampled in idle are ignored. In both cases the pair and `ready` hold their levels.
- R8: If `byte_valid` and `stop_req` are sampled together in escape idle, the byte is sent and the stop request is dropped. The lane returns to escape idle afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_byte | input | 8 | Command byte to send, sampled with `byte_valid` |
| byte_valid | input | 1 | Load `cmd_byte` (honoured only in escape idle) |
| esc_req | input | 1 | Request escape entry (honoured only in idle) |
| stop_req | input | 1 | Request return to idle (honoured only in escape idle) |
| lp_p | output | 1 | Positive wire level of the low-power pair |
| lp_n | output | 1 | Negative wire level of the low-power pair |
| ready | output | 1 | High while the lane is parked and a request can be taken |

## Verification
The byte load and the stop request can both be raised in the single escape-idle cycle, and they compete for the same state transition. The bench raises both together, first in a directed case and then at random points inside the randomized loop. It judges the outcome from the wires alone. The full 16-cycle encoding of the loaded byte must appear, followed by a parked 00 with `ready` high rather than the 00/10/11 stop walk. A second contention is also exercised: random requests are fed during the last busy cycle of every sequence. This confirms that nothing sampled there leaks into the parked state.

// File: rtl/esc_lp_pkg.sv
package esc_lp_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ENT_A,
        PH_ENT_B,
        PH_ENT_C,
        PH_ENT_D,
        PH_ESC,
        PH_MARK,
        PH_SPACE,
        PH_STP_A,
        PH_STP_B
    } phase_e;

    typedef struct packed {
        logic p;
        logic n;
    } lp_pair_t;

    localparam lp_pair_t LVL_HH = '{p: 1'b1, n: 1'b1};
    localparam lp_pair_t LVL_HL = '{p: 1'b1, n: 1'b0};
    localparam lp_pair_t LVL_LH = '{p: 1'b0, n: 1'b1};
    localparam lp_pair_t LVL_LL = '{p: 1'b0, n: 1'b0};

    function automatic lp_pair_t mark_level(input logic b);
        return b ? LVL_HL : LVL_LH;
    endfunction

    function automatic logic phase_parked(input phase_e ph);
        return (ph == PH_IDLE) || (ph == PH_ESC);
    endfunction

endpackage

// File: rtl/esc_bit_shifter.sv
module esc_bit_shifter
    import esc_lp_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter bit LSB_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [DATA_W-1:0] din,
    output logic              cur_bit,
    output logic              last_bit
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] shifted;
    logic [CNT_W-1:0]  cnt;

    generate
        if (LSB_FIRST) begin : g_lsb
            assign cur_bit = shreg[0];
            assign shifted = {1'b0, shreg[DATA_W-1:1]};
        end else begin : g_msb
            assign cur_bit = shreg[DATA_W-1];
            assign shifted = {shreg[DATA_W-2:0], 1'b0};
        end
    endgenerate

    assign last_bit = (cnt == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (load) begin
            shreg <= din;
            cnt   <= '0;
        end else if (advance) begin
            shreg <= shifted;
            cnt   <= cnt + 1'b1;
        end
    end

    // A load and a shift are never requested together by the sequencer.
    assert_load_advance_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(load && advance));

endmodule

// File: rtl/esc_seq_fsm.sv
module esc_seq_fsm
    import esc_lp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   esc_req,
    input  logic   byte_valid,
    input  logic   stop_req,
    input  logic   last_bit,
    output phase_e phase,
    output logic   load,
    output logic   advance
);
    phase_e nxt;

    always_comb begin
        nxt     = phase;
        load    = 1'b0;
        advance = 1'b0;
        case (phase)
            PH_IDLE:  if (esc_req) nxt = PH_ENT_A;
            PH_ENT_A: nxt = PH_ENT_B;
            PH_ENT_B: nxt = PH_ENT_C;
            PH_ENT_C: nxt = PH_ENT_D;
            PH_ENT_D: nxt = PH_ESC;
            PH_ESC: begin
                if (byte_valid) begin
                    nxt  = PH_MARK;
                    load = 1'b1;
                end else if (stop_req) begin
                    nxt = PH_STP_A;
                end
            end
            PH_MARK:  nxt = PH_SPACE;
            PH_SPACE: begin
                advance = 1'b1;
                nxt     = last_bit ? PH_ESC : PH_MARK;
            end
            PH_STP_A: nxt = PH_STP_B;
            PH_STP_B: nxt = PH_IDLE;
            default:  nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end

    assert_mark_then_space_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MARK) |=> (phase == PH_SPACE));

    assert_byte_not_aborted_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MARK || phase == PH_SPACE) |=>
            (phase == PH_MARK || phase == PH_SPACE || phase == PH_ESC));

    assert_escape_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ESC && !byte_valid && !stop_req) |=> (phase == PH_ESC));

    assert_byte_beats_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ESC && byte_valid && stop_req) |=> (phase == PH_MARK));

endmodule

// File: rtl/esc_line_drive.sv
module esc_line_drive
    import esc_lp_pkg::*;
(
    input  phase_e   phase,
    input  logic     cur_bit,
    output lp_pair_t lp,
    output logic     ready
);
    always_comb begin
        case (phase)
            PH_IDLE:  lp = LVL_HH;
            PH_ENT_A: lp = LVL_HL;
            PH_ENT_B: lp = LVL_LL;
            PH_ENT_C: lp = LVL_LH;
            PH_ENT_D: lp = LVL_LL;
            PH_ESC:   lp = LVL_LL;
            PH_MARK:  lp = mark_level(cur_bit);
            PH_SPACE: lp = LVL_LL;
            PH_STP_A: lp = LVL_LL;
            PH_STP_B: lp = LVL_HL;
            default:  lp = LVL_HH;
        endcase
    end

    assign ready = phase_parked(phase);

endmodule

// File: rtl/esc_lp_encoder.sv
module esc_lp_encoder
    import esc_lp_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter bit LSB_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] cmd_byte,
    input  logic              byte_valid,
    input  logic              esc_req,
    input  logic              stop_req,
    output logic              lp_p,
    output logic              lp_n,
    output logic              ready
);
    phase_e   phase;
    logic     load;
    logic     advance;
    logic     cur_bit;
    logic     last_bit;
    lp_pair_t lp;

    esc_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .esc_req    (esc_req),
        .byte_valid (byte_valid),
        .stop_req   (stop_req),
        .last_bit   (last_bit),
        .phase      (phase),
        .load       (load),
        .advance    (advance)
    );

    esc_bit_shifter #(
        .DATA_W    (DATA_W),
        .LSB_FIRST (LSB_FIRST)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .advance  (advance),
        .din      (cmd_byte),
        .cur_bit  (cur_bit),
        .last_bit (last_bit)
    );

    esc_line_drive u_drive (
        .phase   (phase),
        .cur_bit (cur_bit),
        .lp      (lp),
        .ready   (ready)
    );

    assign lp_p = lp.p;
    assign lp_n = lp.n;

    assert_high_high_is_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (lp_p && lp_n) |-> ready);

    assert_entry_first_step_R2: assert property (@(posedge clk) disable iff (rst)
        (ready && lp_p && lp_n && esc_req) |=> (lp_p && !lp_n && !ready));

    assert_byte_first_mark_R3: assert property (@(posedge clk) disable iff (rst)
        (ready && !lp_p && !lp_n && byte_valid) |=> (!ready && (lp_p ^ lp_n)));

    assert_park_after_space_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready) && !lp_p && !lp_n) |-> $past(!lp_p && !lp_n));

    assert_stop_first_step_R5: assert property (@(posedge clk) disable iff (rst)
        (ready && !lp_p && !lp_n && stop_req && !byte_valid) |=> (!ready && !lp_p && !lp_n));

    assert_stop_final_step_R5: assert property (@(posedge clk) disable iff (rst)
        (ready && lp_p && lp_n && $past(!ready)) |-> $past(lp_p && !lp_n));

endmodule

// File: tb/esc_lp_encoder_bench.sv
module esc_lp_encoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int WATCHDOG   = 100000;
    localparam int SEED       = 20240611;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DATA_W-1:0] cmd_byte;
    logic              byte_valid;
    logic              esc_req;
    logic              stop_req;
    logic              lp_p;
    logic              lp_n;
    logic              ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    esc_lp_encoder #(.DATA_W(DATA_W), .LSB_FIRST(1'b1)) u_esc_lp_encoder (
        .clk        (clk),
        .rst        (rst),
        .cmd_byte   (cmd_byte),
        .byte_valid (byte_valid),
        .esc_req    (esc_req),
        .stop_req   (stop_req),
        .lp_p       (lp_p),
        .lp_n       (lp_n),
        .ready      (ready)
    );

    // Expected triples are {lp_p, lp_n, ready}.
    localparam logic [2:0] EXP_IDLE  = 3'b111;
    localparam logic [2:0] EXP_ESC   = 3'b001;
    localparam logic [2:0] EXP_LL    = 3'b000;
    localparam logic [2:0] EXP_HL    = 3'b100;
    localparam logic [2:0] EXP_LH    = 3'b010;

    function automatic logic [2:0] exp_mark(input logic b);
        return b ? EXP_HL : EXP_LH;
    endfunction

    function automatic logic [2:0] obs();
        return {lp_p, lp_n, ready};
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: p/n/ready actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_in(input logic bv, input logic sr, input logic er, input logic [DATA_W-1:0] d);
        byte_valid = bv;
        stop_req   = sr;
        esc_req    = er;
        cmd_byte   = d;
    endtask

    task automatic idle_in();
        set_in(1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic noise_in(input bit noisy);
        if (noisy) set_in(1'($urandom), 1'($urandom), 1'($urandom), DATA_W'($urandom));
        else       idle_in();
    endtask

    task automatic enter_escape(input bit noisy);
        set_in(1'b0, 1'b0, 1'b1, '0);
        @(negedge clk); check("R2 entry step1 LP10 (R6 noise)", obs(), EXP_HL); noise_in(noisy);
        @(negedge clk); check("R2 entry step2 LP00 (R6 noise)", obs(), EXP_LL); noise_in(noisy);
        @(negedge clk); check("R2 entry step3 LP01 (R6 noise)", obs(), EXP_LH); noise_in(noisy);
        @(negedge clk); check("R2 entry step4 LP00 (R6 noise)", obs(), EXP_LL); noise_in(noisy);
        @(negedge clk); check("R2 escape idle reached", obs(), EXP_ESC); idle_in();
    endtask

    task automatic send_byte(input logic [DATA_W-1:0] d, input bit noisy, input bit with_stop);
        set_in(1'b1, with_stop, 1'b0, d);
        for (int i = 0; i < DATA_W; i++) begin
            @(negedge clk);
            check(with_stop ? "R8 mark despite stop" : "R3 mark bit (R6 noise)", obs(), exp_mark(d[i]));
            noise_in(noisy);
            @(negedge clk);
            check("R3 space state (R6 noise)", obs(), EXP_LL);
            noise_in(noisy);
        end
        @(negedge clk);
        check(with_stop ? "R8 parked in escape after byte" : "R4 ready after last space", obs(), EXP_ESC);
        idle_in();
    endtask

    task automatic do_stop(input bit noisy);
        set_in(1'b0, 1'b1, 1'b0, '0);
        @(negedge clk); check("R5 stop step1 LP00 (R6 noise)", obs(), EXP_LL); noise_in(noisy);
        @(negedge clk); check("R5 stop step2 LP10 (R6 noise)", obs(), EXP_HL); noise_in(noisy);
        @(negedge clk); check("R5 stop reaches LP11 ready", obs(), EXP_IDLE); idle_in();
    endtask

    task automatic idle_ignores();
        set_in(1'b1, 1'b1, 1'b0, 8'hFF);
        @(negedge clk); check("R7 idle ignores byte/stop", obs(), EXP_IDLE); idle_in();
    endtask

    task automatic escape_ignores_esc();
        set_in(1'b0, 1'b0, 1'b1, 8'h5A);
        @(negedge clk); check("R7 escape ignores esc_req", obs(), EXP_ESC); idle_in();
    endtask

    task automatic finish_bench();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finish within %0d cycles", WATCHDOG);
            finish_bench();
        end
    end

    initial begin
        int nb;
        void'($urandom(SEED));
        idle_in();
        repeat (3) @(negedge clk);
        check("R1 state during reset", obs(), EXP_IDLE);
        rst = 1'b0;
        @(negedge clk); check("R1 state after reset", obs(), EXP_IDLE);

        idle_ignores();
        enter_escape(1'b0);
        escape_ignores_esc();
        send_byte(8'hA5, 1'b0, 1'b0);
        send_byte(8'h00, 1'b0, 1'b0);
        send_byte(8'hFF, 1'b1, 1'b0);
        send_byte(8'h3C, 1'b0, 1'b1);
        @(negedge clk); check("R8 stop dropped, still escape idle", obs(), EXP_ESC);
        do_stop(1'b0);
        idle_ignores();

        for (int it = 0; it < 40; it++) begin
            enter_escape(1'b1);
            if (it % 4 == 1) escape_ignores_esc();
            nb = 1 + int'($urandom % 4);
            for (int k = 0; k < nb; k++)
                send_byte(DATA_W'($urandom), 1'b1, 1'($urandom));
            do_stop(1'b1);
            if (it % 3 == 0) idle_ignores();
        end

        finish_bench();
    end

endmodule